// File: doc/BRIEF.md
# System Control Register File

This block holds the control state that a processor core reaches through coprocessor-style register moves. Each request presents a 32-bit instruction word, a write strobe and write data for one cycle. The block takes a primary register number from bits 19:16 of the word and a secondary selector from bits 7:5. All other bits are ignored. It answers one cycle later with read data, an illegal-access pulse and, for some writes, a pulse that tells the translation lookaside buffer to flush.

The block holds the control word, coprocessor access rights, the translation table base, the domain access word, separate data-side and instruction-side fault status and fault address, two lockdown words, a process address offset and a context identifier. A translation unit can load a fault status and address pair directly through a capture port. Selections that exist only for caches or tightly coupled memory read as zero and ignore writes. Reserved selections raise the illegal pulse.

Top module: `sysctl_regs`

## Requirements
- R1: A request in cycle N gives `rspValid` high in cycle N+1, together with `rspData`, `rspIllegal` and `tlbFlush`. With no request, all four are zero in the next cycle. Writes return zero data.
- R2: Register 0 is read-only. Selector 1 reads `CACHE_TYPE`, selector 2 reads zero and every other selector reads `DEVICE_ID`. Any write to register 0 is illegal.
- R3: Register 1 selector 0 is the control word. Writing it stores the data and pulses `tlbFlush`. Reading selector 1 gives 1, and writing selector 1 is illegal. Selector 2 is a read/write access-rights word. Selectors 3 to 7 are illegal.
- R4: Registers 2 (table base) and 3 (domain access) are read/write for every selector value.
- R5: Register 5 holds fault status and register 6 holds fault address. Selector 0 is the data side and selector 1 the instruction side, for both reads and writes. Other selectors are illegal.
- R6: A write to register 8 with selector 0 or 1 pulses `tlbFlush` and stores nothing. Any read of register 8, and a write with any other selector, is illegal.
- R7: Register 9 holds two lockdown words, data on selector 0 and instruction on selector 1. Other selectors are illegal.
- R8: Register 13 holds the process address offset on selector 0 and the context identifier on selector 1. Other selectors are illegal.
- R9: Any access to register 4, 11, 12 or 14 is illegal.
- R10: Registers 7, 10 and 15 read as zero for any selector. Writes to them are accepted without illegal and change nothing.
- R11: An illegal access pulses `rspIllegal` for one cycle with `rspData` zero and no flush, and it changes no register.
- R12: When `fltValid` is high at a clock edge, the fault status and address of the side chosen by `fltIsInsn` (0 data, 1 instruction) are loaded at that edge. A software write to the same register in the same cycle is discarded.
- R13: After reset every stored register reads zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 write, 0 read |
| reqInsn | input | 32 | Move instruction word (register 19:16, selector 7:5) |
| reqWdata | input | DATA_W | Write data |
| fltValid | input | 1 | Fault capture strobe |
| fltIsInsn | input | 1 | Capture side: 0 data, 1 instruction |
| fltStatus | input | DATA_W | Captured fault status |
| fltAddr | input | DATA_W | Captured fault address |
| rspValid | output | 1 | Response for previous cycle's request |
| rspData | output | DATA_W | Read data (zero on writes and illegal) |
| rspIllegal | output | 1 | One-cycle illegal-access pulse |
| tlbFlush | output | 1 | One-cycle full flush pulse |

## Verification
Every result is due exactly one clock after its request, and a write or capture becomes visible to a read issued in the cycle after it. The bench drives stimulus on the falling edge. A behavioural model updates on the rising edge and forms the expected response from the request seen at that edge. Outputs are compared with the model on the next falling edge, so each check samples the response exactly one cycle after its request. The stimulus sweeps every register and selector for reads and writes, captures faults alone and together with a colliding write, and then runs a long stream of mixed requests.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  typedef enum logic [3:0] {
    RD_ZERO, RD_DEVID, RD_CACHE, RD_ONE, RD_CTRL, RD_ACCESS, RD_TBASE, RD_DOMAIN,
    RD_FSTAT_D, RD_FSTAT_I, RD_FADDR_D, RD_FADDR_I, RD_LOCK_D, RD_LOCK_I, RD_PIDOFS, RD_CTXID
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrAccess;
    logic   wrTbase;
    logic   wrDomain;
    logic   wrFstatD;
    logic   wrFstatI;
    logic   wrFaddrD;
    logic   wrFaddrI;
    logic   wrLockD;
    logic   wrLockI;
    logic   wrPidOfs;
    logic   wrCtxId;
    logic   flush;
    logic   illegal;
    rdSel_e rdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int REG_LSB = 16,
  parameter int SEL_LSB = 5
) (
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [31:0] reqInsn,
  output ctlStrobes_t ctl
);
  localparam int REG_W = 4;
  localparam int SEL_W = 3;

  logic [REG_W-1:0] regNum;
  logic [SEL_W-1:0] sel;
  logic             wr;

  assign regNum = reqInsn[REG_LSB +: REG_W];
  assign sel    = reqInsn[SEL_LSB +: SEL_W];
  assign wr     = reqWrite;

  always_comb begin
    ctl       = '0;
    ctl.rdSel = RD_ZERO;
    if (reqValid) begin
      case (regNum)
        4'd0: begin
          if (wr) ctl.illegal = 1'b1;
          else if (sel == 3'd1) ctl.rdSel = RD_CACHE;
          else if (sel == 3'd2) ctl.rdSel = RD_ZERO;
          else ctl.rdSel = RD_DEVID;
        end
        4'd1: begin
          case (sel)
            3'd0: if (wr) begin ctl.wrCtrl = 1'b1; ctl.flush = 1'b1; end
                  else ctl.rdSel = RD_CTRL;
            3'd1: if (wr) ctl.illegal = 1'b1; else ctl.rdSel = RD_ONE;
            3'd2: if (wr) ctl.wrAccess = 1'b1; else ctl.rdSel = RD_ACCESS;
            default: ctl.illegal = 1'b1;
          endcase
        end
        4'd2: if (wr) ctl.wrTbase = 1'b1; else ctl.rdSel = RD_TBASE;
        4'd3: if (wr) ctl.wrDomain = 1'b1; else ctl.rdSel = RD_DOMAIN;
        4'd5: begin
          case (sel)
            3'd0: if (wr) ctl.wrFstatD = 1'b1; else ctl.rdSel = RD_FSTAT_D;
            3'd1: if (wr) ctl.wrFstatI = 1'b1; else ctl.rdSel = RD_FSTAT_I;
            default: ctl.illegal = 1'b1;
          endcase
        end
        4'd6: begin
          case (sel)
            3'd0: if (wr) ctl.wrFaddrD = 1'b1; else ctl.rdSel = RD_FADDR_D;
            3'd1: if (wr) ctl.wrFaddrI = 1'b1; else ctl.rdSel = RD_FADDR_I;
            default: ctl.illegal = 1'b1;
          endcase
        end
        4'd7, 4'd10, 4'd15: ctl.rdSel = RD_ZERO;
        4'd8: begin
          if (wr && (sel == 3'd0 || sel == 3'd1)) ctl.flush = 1'b1;
          else ctl.illegal = 1'b1;
        end
        4'd9: begin
          case (sel)
            3'd0: if (wr) ctl.wrLockD = 1'b1; else ctl.rdSel = RD_LOCK_D;
            3'd1: if (wr) ctl.wrLockI = 1'b1; else ctl.rdSel = RD_LOCK_I;
            default: ctl.illegal = 1'b1;
          endcase
        end
        4'd13: begin
          case (sel)
            3'd0: if (wr) ctl.wrPidOfs = 1'b1; else ctl.rdSel = RD_PIDOFS;
            3'd1: if (wr) ctl.wrCtxId = 1'b1; else ctl.rdSel = RD_CTXID;
            default: ctl.illegal = 1'b1;
          endcase
        end
        default: ctl.illegal = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/sysctl_datapath.sv
module sysctl_datapath
  import sysctl_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter logic [DATA_W-1:0] DEVICE_ID  = 32'h5A01_C0DE,
  parameter logic [DATA_W-1:0] CACHE_TYPE = 32'h0012_3456
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  ctlStrobes_t       ctl,
  input  logic              fltValid,
  input  logic              fltIsInsn,
  input  logic [DATA_W-1:0] fltStatus,
  input  logic [DATA_W-1:0] fltAddr,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspIllegal,
  output logic              tlbFlush
);
  localparam logic [DATA_W-1:0] ONE_VAL = DATA_W'(1);

  logic [DATA_W-1:0] ctrlReg, accessReg, tbaseReg, domainReg;
  logic [DATA_W-1:0] fstatD, fstatI, faddrD, faddrI;
  logic [DATA_W-1:0] lockD, lockI, pidOfs, ctxId;
  logic [DATA_W-1:0] rdMux;
  logic              capD, capI;

  assign capD = fltValid && !fltIsInsn;
  assign capI = fltValid && fltIsInsn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0; accessReg <= '0; tbaseReg <= '0; domainReg <= '0;
      lockD <= '0; lockI <= '0; pidOfs <= '0; ctxId <= '0;
    end else begin
      if (ctl.wrCtrl)   ctrlReg   <= reqWdata;
      if (ctl.wrAccess) accessReg <= reqWdata;
      if (ctl.wrTbase)  tbaseReg  <= reqWdata;
      if (ctl.wrDomain) domainReg <= reqWdata;
      if (ctl.wrLockD)  lockD     <= reqWdata;
      if (ctl.wrLockI)  lockI     <= reqWdata;
      if (ctl.wrPidOfs) pidOfs    <= reqWdata;
      if (ctl.wrCtxId)  ctxId     <= reqWdata;
    end
  end

  // Hardware capture outranks a colliding software write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fstatD <= '0; fstatI <= '0; faddrD <= '0; faddrI <= '0;
    end else begin
      if (capD) begin fstatD <= fltStatus; faddrD <= fltAddr; end
      else begin
        if (ctl.wrFstatD) fstatD <= reqWdata;
        if (ctl.wrFaddrD) faddrD <= reqWdata;
      end
      if (capI) begin fstatI <= fltStatus; faddrI <= fltAddr; end
      else begin
        if (ctl.wrFstatI) fstatI <= reqWdata;
        if (ctl.wrFaddrI) faddrI <= reqWdata;
      end
    end
  end

  always_comb begin
    unique case (ctl.rdSel)
      RD_DEVID:   rdMux = DEVICE_ID;
      RD_CACHE:   rdMux = CACHE_TYPE;
      RD_ONE:     rdMux = ONE_VAL;
      RD_CTRL:    rdMux = ctrlReg;
      RD_ACCESS:  rdMux = accessReg;
      RD_TBASE:   rdMux = tbaseReg;
      RD_DOMAIN:  rdMux = domainReg;
      RD_FSTAT_D: rdMux = fstatD;
      RD_FSTAT_I: rdMux = fstatI;
      RD_FADDR_D: rdMux = faddrD;
      RD_FADDR_I: rdMux = faddrI;
      RD_LOCK_D:  rdMux = lockD;
      RD_LOCK_I:  rdMux = lockI;
      RD_PIDOFS:  rdMux = pidOfs;
      RD_CTXID:   rdMux = ctxId;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0; rspData <= '0; rspIllegal <= 1'b0; tlbFlush <= 1'b0;
    end else begin
      rspValid   <= reqValid;
      rspIllegal <= ctl.illegal;
      tlbFlush   <= ctl.flush && !ctl.illegal;
      rspData    <= ctl.illegal ? '0 : rdMux;
    end
  end

  // R1: response follows its request by one cycle
  a_r1_rsp_after_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r1_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid && !rspIllegal && !tlbFlush);
  // R11: illegal response carries zero data and no flush
  a_r11_illegal_clean: assert property (@(posedge clk) disable iff (!rstN)
    rspIllegal |-> (rspData == '0) && !tlbFlush && rspValid);
  // R11: illegal access leaves software registers untouched
  a_r11_illegal_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    ctl.illegal |=> $stable(ctrlReg) && $stable(accessReg) && $stable(tbaseReg)
      && $stable(domainReg) && $stable(pidOfs) && $stable(ctxId));
  // R6: a flush pulse only ever follows a write request
  a_r6_flush_from_write: assert property (@(posedge clk) disable iff (!rstN)
    tlbFlush |-> $past(reqValid && reqWrite));
  // R12: data-side capture wins over any same-cycle write
  a_r12_capture_data: assert property (@(posedge clk) disable iff (!rstN)
    capD |=> (fstatD == $past(fltStatus)) && (faddrD == $past(fltAddr)));
  a_r12_capture_insn: assert property (@(posedge clk) disable iff (!rstN)
    capI |=> (fstatI == $past(fltStatus)) && (faddrI == $past(fltAddr)));

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] DEVICE_ID  = 32'h5A01_C0DE,
  parameter logic [DATA_W-1:0] CACHE_TYPE = 32'h0012_3456
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [31:0]       reqInsn,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              fltValid,
  input  logic              fltIsInsn,
  input  logic [DATA_W-1:0] fltStatus,
  input  logic [DATA_W-1:0] fltAddr,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspIllegal,
  output logic              tlbFlush
);
  ctlStrobes_t ctl;

  sysctl_decode #(.REG_LSB(16), .SEL_LSB(5)) u_decode (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqInsn  (reqInsn),
    .ctl      (ctl)
  );

  sysctl_datapath #(.DATA_W(DATA_W), .DEVICE_ID(DEVICE_ID), .CACHE_TYPE(CACHE_TYPE)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqWdata   (reqWdata),
    .ctl        (ctl),
    .fltValid   (fltValid),
    .fltIsInsn  (fltIsInsn),
    .fltStatus  (fltStatus),
    .fltAddr    (fltAddr),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .rspIllegal (rspIllegal),
    .tlbFlush   (tlbFlush)
  );

endmodule

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;
  localparam logic [31:0] DEVID = 32'h5A01_C0DE;
  localparam logic [31:0] CTYPE = 32'h0012_3456;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqInsn = '0, reqWdata = '0;
  logic        fltValid = 1'b0, fltIsInsn = 1'b0;
  logic [31:0] fltStatus = '0, fltAddr = '0;
  logic        rspValid, rspIllegal, tlbFlush;
  logic [31:0] rspData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sysctl_regs u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqInsn(reqInsn), .reqWdata(reqWdata), .fltValid(fltValid),
    .fltIsInsn(fltIsInsn), .fltStatus(fltStatus), .fltAddr(fltAddr),
    .rspValid(rspValid), .rspData(rspData), .rspIllegal(rspIllegal),
    .tlbFlush(tlbFlush)
  );

  // Behavioural model state
  logic [31:0] mCtrl, mAcc, mTb, mDom, mFsD, mFsI, mFaD, mFaI, mLkD, mLkI, mPid, mCtx;
  logic        eValid, eIll, eFlush;
  logic [31:0] eData;
  string       eTag;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {mCtrl, mAcc, mTb, mDom, mFsD, mFsI, mFaD, mFaI, mLkD, mLkI, mPid, mCtx} = '0;
      eValid = 0; eIll = 0; eFlush = 0; eData = 0; eTag = "R13";
    end else begin
      int r, s;
      bit w;
      eValid = reqValid; eIll = 0; eFlush = 0; eData = 0; eTag = "R1";
      if (reqValid) begin
        r = int'(reqInsn[19:16]); s = int'(reqInsn[7:5]); w = reqWrite;
        if (r == 0) begin
          eTag = "R2";
          if (w) eIll = 1; else eData = (s == 1) ? CTYPE : (s == 2) ? 32'd0 : DEVID;
        end else if (r == 1) begin
          eTag = "R3";
          if (s == 0) begin if (w) begin mCtrl = reqWdata; eFlush = 1; end else eData = mCtrl; end
          else if (s == 1) begin if (w) eIll = 1; else eData = 32'd1; end
          else if (s == 2) begin if (w) mAcc = reqWdata; else eData = mAcc; end
          else eIll = 1;
        end else if (r == 2) begin
          eTag = "R4"; if (w) mTb = reqWdata; else eData = mTb;
        end else if (r == 3) begin
          eTag = "R4"; if (w) mDom = reqWdata; else eData = mDom;
        end else if (r == 5) begin
          eTag = "R5 R12";
          if (s == 0) begin if (w) mFsD = reqWdata; else eData = mFsD; end
          else if (s == 1) begin if (w) mFsI = reqWdata; else eData = mFsI; end
          else eIll = 1;
        end else if (r == 6) begin
          eTag = "R5 R12";
          if (s == 0) begin if (w) mFaD = reqWdata; else eData = mFaD; end
          else if (s == 1) begin if (w) mFaI = reqWdata; else eData = mFaI; end
          else eIll = 1;
        end else if (r == 8) begin
          eTag = "R6";
          if (w && s <= 1) eFlush = 1; else eIll = 1;
        end else if (r == 9) begin
          eTag = "R7";
          if (s == 0) begin if (w) mLkD = reqWdata; else eData = mLkD; end
          else if (s == 1) begin if (w) mLkI = reqWdata; else eData = mLkI; end
          else eIll = 1;
        end else if (r == 13) begin
          eTag = "R8";
          if (s == 0) begin if (w) mPid = reqWdata; else eData = mPid; end
          else if (s == 1) begin if (w) mCtx = reqWdata; else eData = mCtx; end
          else eIll = 1;
        end else if (r == 7 || r == 10 || r == 15) begin
          eTag = "R10";
        end else begin
          eTag = "R9"; eIll = 1;
        end
        if (eIll) begin eTag = {eTag, " R11"}; eData = 0; end
      end
      // Hardware capture lands after, and so overrides, any write.
      if (fltValid) begin
        if (fltIsInsn) begin mFsI = fltStatus; mFaI = fltAddr; end
        else begin mFsD = fltStatus; mFaD = fltAddr; end
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(eTag, "rspValid", 32'(rspValid), 32'(eValid));
      check(eTag, "rspData", rspData, eData);
      check(eTag, "rspIllegal", 32'(rspIllegal), 32'(eIll));
      check(eTag, "tlbFlush", 32'(tlbFlush), 32'(eFlush));
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] mkInsn(input int r, input int s, input logic [31:0] junk);
    logic [31:0] v;
    v = junk;
    v[19:16] = 4'(r);
    v[7:5]   = 3'(s);
    return v;
  endfunction

  task automatic drive(input bit v, input bit w, input int r, input int s,
                       input logic [31:0] d, input bit fv, input bit fi,
                       input logic [31:0] fs, input logic [31:0] fa);
    @(negedge clk);
    reqValid = v; reqWrite = w; reqInsn = mkInsn(r, s, $urandom()); reqWdata = d;
    fltValid = fv; fltIsInsn = fi; fltStatus = fs; fltAddr = fa;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R13: outputs low while and just after reset
    check("R13", "rspValid", 32'(rspValid), 0);
    check("R13", "rspData", rspData, 0);
    check("R13", "rspIllegal", 32'(rspIllegal), 0);
    check("R13", "tlbFlush", 32'(tlbFlush), 0);
    rstN = 1'b1;
    // R13 R2 R9: read sweep from reset values
    for (int r = 0; r < 16; r++)
      for (int s = 0; s < 8; s++) drive(1, 0, r, s, 0, 0, 0, 0, 0);
    idle();
    // Write sweep with distinct values, then read back
    for (int r = 0; r < 16; r++)
      for (int s = 0; s < 8; s++) drive(1, 1, r, s, 32'hA500_0000 | (r << 8) | s, 0, 0, 0, 0);
    for (int r = 0; r < 16; r++)
      for (int s = 0; s < 8; s++) drive(1, 0, r, s, 0, 0, 0, 0, 0);
    // R12: standalone captures then readback
    drive(0, 0, 0, 0, 0, 1, 0, 32'h0000_00D5, 32'hDEAD_0004);
    drive(0, 0, 0, 0, 0, 1, 1, 32'h0000_0017, 32'hBEEF_0008);
    for (int r = 5; r < 7; r++)
      for (int s = 0; s < 2; s++) drive(1, 0, r, s, 0, 0, 0, 0, 0);
    // R12: capture collides with a software write to the same register
    drive(1, 1, 5, 0, 32'h1111_1111, 1, 0, 32'h2222_2222, 32'h3333_3333);
    drive(1, 1, 6, 1, 32'h4444_4444, 1, 1, 32'h5555_5555, 32'h6666_6666);
    for (int r = 5; r < 7; r++)
      for (int s = 0; s < 2; s++) drive(1, 0, r, s, 0, 0, 0, 0, 0);
    // Back-to-back write then read of the same register
    drive(1, 1, 1, 0, 32'h0000_2001, 0, 0, 0, 0);
    drive(1, 0, 1, 0, 0, 0, 0, 0, 0);
    // Mixed stream
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom_range(0, 9) != 0);
      drive(v, $urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 7), $urandom(),
            ($urandom_range(0, 7) == 0), $urandom_range(0, 1), $urandom(), $urandom());
    end
    idle();
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule